// File: doc/BRIEF.md
# Strap-Selected Clock Divider Bank with Hitless Memory-Clock Boost

This block derives five board clocks from one fast source clock: a processor clock, a memory (SDRAM) clock, a hub clock, a PCI clock and an interrupt-controller (IOAPIC) clock. With a nominal 400 MHz reference, the processor clock runs at about 66, 100 or 133 MHz and the memory clock at 100 or 133 MHz. The hub clock stays near 66 MHz, and the PCI and IOAPIC clocks stay near 33 MHz. Two speed straps choose the processor and memory ratios. They are captured while reset is held and are frozen once reset is released.

A boost input can move the memory clock from the 100 MHz ratio to the 133 MHz ratio at run time. It has this effect only when the straps select the 133 MHz processor speed. The new ratio is applied only at the common alignment point, where every divider returns to zero together, so no output shows a short pulse. A test-mode strap switches the source to an external test clock and uses fixed small divisions of it. The PCI and IOAPIC clocks are the same waveform, delayed by a fixed number of source cycles behind the hub clock.

Top module: `fs_clock_divider`

## Requirements
- R1: With the boost off and test mode off, the CPU ratio depends on the captured straps fs_sel. 2'b00 divides by 6, 2'b01 divides by 4, and 2'b10 or 2'b11 divides by 3.
- R2: The SDRAM ratio is 4 by default. It is 3 when fs_sel is 2'b10, and 3 when fs_sel is 2'b11 with sdram_boost at 1.
- R3: Outside test mode, hub_clk divides the source by 6 and pci_clk divides it by 12. Neither changes when sdram_boost changes.
- R4: sdram_boost has no effect when the captured straps are 2'b00 or 2'b01, and the SDRAM ratio stays 4.
- R5: fs_sel is sampled on every source edge while rst_n is low. Changes to fs_sel after reset is released have no effect on any ratio.
- R6: When test_mode is held at 1 through reset, test_clk is the source. In that mode cpu_clk and sdram_clk divide by 2, hub_clk divides by 3, and pci_clk and apic_clk divide by 6.
- R7: Every output is high for exactly half of its ratio, in source half-periods. A ratio of 3 gives 1.5 source periods high and 1.5 low, using the falling edge.
- R8: A change of the SDRAM ratio takes effect only at the 12-cycle frame boundary. During the change, no SDRAM high or low phase is shorter than 1.5 source periods, and cpu_clk keeps its exact period.
- R9: apic_clk equals pci_clk at all times. Their rising edges come PCI_LAG source cycles after a hub_clk rising edge.
- R10: While rst_n is low, all five outputs are held low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Fast reference clock, nominally 400 MHz |
| test_clk | input | 1 | External test clock, used as the source when test_mode is 1 |
| rst_n | input | 1 | Active-low reset, synchronous to the selected source |
| test_mode | input | 1 | Test-mode strap; may change only while rst_n is low |
| fs_sel | input | 2 | Speed straps, captured during reset |
| sdram_boost | input | 1 | Run-time request for the faster memory ratio |
| cpu_clk | output | 1 | Processor clock |
| sdram_clk | output | 1 | Memory clock |
| hub_clk | output | 1 | Hub clock |
| pci_clk | output | 1 | PCI clock, delayed behind the hub clock |
| apic_clk | output | 1 | Interrupt-controller clock, identical to pci_clk |

## Verification
A wrong captured strap or ratio register shows up as a wrong high or low run length on the affected output. This is visible within the first output period after reset, at most 12 source cycles. A ratio applied away from the frame boundary leaves the memory clock with a run shorter than 1.5 source periods, or leaves it out of step with the processor clock at the next frame start, within one 12-cycle frame. A wrong half-cycle path on the ratio-3 outputs breaks the 1.5/1.5 duty on the first period. A wrong PCI delay changes the spacing from the PCI edge to the next hub edge at once.

// File: rtl/fsdiv_pkg.sv
package fsdiv_pkg;
  localparam int RW    = 4;
  localparam int NOUT  = 5;
  localparam int I_CPU = 0;
  localparam int I_SD  = 1;
  localparam int I_HUB = 2;
  localparam int I_PCI = 3;
  localparam int I_API = 4;

  typedef logic [RW-1:0] ratio_t;

  typedef enum logic [1:0] {
    SPD_LOW  = 2'b00,
    SPD_MID  = 2'b01,
    SPD_TOPA = 2'b10,
    SPD_TOPB = 2'b11
  } speed_e;

  function automatic ratio_t cpu_ratio(input speed_e spd, input logic tm);
    if (tm) return ratio_t'(2);
    case (spd)
      SPD_LOW: return ratio_t'(6);
      SPD_MID: return ratio_t'(4);
      default: return ratio_t'(3);
    endcase
  endfunction

  function automatic ratio_t sdram_ratio(input speed_e spd, input logic boost, input logic tm);
    if (tm) return ratio_t'(2);
    if (spd == SPD_TOPA) return ratio_t'(3);
    if (spd == SPD_TOPB && boost) return ratio_t'(3);
    return ratio_t'(4);
  endfunction

  function automatic ratio_t hub_ratio(input logic tm);
    return tm ? ratio_t'(3) : ratio_t'(6);
  endfunction

  function automatic ratio_t pci_ratio(input logic tm);
    return tm ? ratio_t'(6) : ratio_t'(12);
  endfunction
endpackage

// File: rtl/fsdiv_cfg.sv
module fsdiv_cfg
  import fsdiv_pkg::*;
#(
  parameter int FRAME = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tm_pin,
  input  logic [1:0]            fs_pin,
  input  logic                  boost_pin,
  output ratio_t [NOUT-1:0]     req,
  output logic                  frame_end,
  output logic                  phase_zero
);
  localparam int PW = (FRAME > 1) ? $clog2(FRAME) : 1;
  localparam logic [PW-1:0] LAST = PW'(FRAME - 1);

  speed_e         spd_q;
  logic           tm_q;
  logic [1:0]     bst_sync;
  logic [PW-1:0]  phase_q;

  // Straps follow the pins while reset is held and are frozen afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spd_q    <= speed_e'(fs_pin);
      tm_q     <= tm_pin;
      bst_sync <= 2'b00;
      phase_q  <= LAST;
    end else begin
      bst_sync <= {bst_sync[0], boost_pin};
      phase_q  <= frame_end ? '0 : phase_q + 1'b1;
    end
  end

  assign frame_end  = (phase_q == LAST);
  assign phase_zero = (phase_q == '0);

  always_comb begin
    req        = '0;
    req[I_CPU] = cpu_ratio(spd_q, tm_q);
    req[I_SD]  = sdram_ratio(spd_q, bst_sync[1], tm_q);
    req[I_HUB] = hub_ratio(tm_q);
    req[I_PCI] = pci_ratio(tm_q);
    req[I_API] = pci_ratio(tm_q);
  end
endmodule

// File: rtl/fsdiv_cell.sv
module fsdiv_cell
  import fsdiv_pkg::*;
#(
  parameter int RATIO_RST = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  ratio_t ratio_req,
  output ratio_t ratio_now,
  output logic   clk_out
);
  ratio_t ratio_q, cnt_q, cnt_d, ratio_use, half_use;
  logic   hi_q, lo_q;

  // A new ratio is taken only on a load cycle, where the count restarts at zero.
  always_comb begin
    ratio_use = load ? ratio_req : ratio_q;
    half_use  = ratio_use >> 1;
    if (load || (cnt_q >= ratio_q - 1'b1)) cnt_d = '0;
    else                                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ratio_q <= ratio_t'(RATIO_RST);
      cnt_q   <= '0;
      hi_q    <= 1'b0;
    end else begin
      ratio_q <= ratio_use;
      cnt_q   <= cnt_d;
      hi_q    <= (cnt_d < half_use);
    end
  end

  // Half-cycle copy widens the high phase of odd ratios by half a period.
  always_ff @(negedge clk) begin
    if (!rst_n) lo_q <= 1'b0;
    else        lo_q <= hi_q;
  end

  assign clk_out   = ratio_q[0] ? (hi_q | lo_q) : hi_q;
  assign ratio_now = ratio_q;
endmodule

// File: rtl/fsdiv_lag.sv
module fsdiv_lag #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_none
      assign q = d;
    end else if (DEPTH == 1) begin : g_one
      logic r_q;
      always_ff @(posedge clk) begin
        if (!rst_n) r_q <= 1'b0;
        else        r_q <= d;
      end
      assign q = r_q;
    end else begin : g_many
      logic [DEPTH-1:0] sh_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[DEPTH-2:0], d};
      end
      assign q = sh_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/fs_clock_divider.sv
module fs_clock_divider
  import fsdiv_pkg::*;
#(
  parameter int FRAME   = 12,
  parameter int PCI_LAG = 2
) (
  input  logic       ref_clk,
  input  logic       test_clk,
  input  logic       rst_n,
  input  logic       test_mode,
  input  logic [1:0] fs_sel,
  input  logic       sdram_boost,
  output logic       cpu_clk,
  output logic       sdram_clk,
  output logic       hub_clk,
  output logic       pci_clk,
  output logic       apic_clk
);
  logic                src_clk;
  ratio_t [NOUT-1:0]   req;
  ratio_t [NOUT-1:0]   active_ratio;
  logic   [NOUT-1:0]   raw_clk;
  logic                frame_end;
  logic                phase_zero;
  ratio_t              cpu_ratio_now;
  ratio_t              sd_ratio_now;

  // test_mode is a strap: it may change only while rst_n is low.
  assign src_clk = test_mode ? test_clk : ref_clk;

  fsdiv_cfg #(.FRAME(FRAME)) u_cfg (
    .clk        (src_clk),
    .rst_n      (rst_n),
    .tm_pin     (test_mode),
    .fs_pin     (fs_sel),
    .boost_pin  (sdram_boost),
    .req        (req),
    .frame_end  (frame_end),
    .phase_zero (phase_zero)
  );

  generate
    for (genvar g = 0; g < NOUT; g++) begin : g_cell
      fsdiv_cell #(.RATIO_RST(2)) u_cell (
        .clk       (src_clk),
        .rst_n     (rst_n),
        .load      (frame_end),
        .ratio_req (req[g]),
        .ratio_now (active_ratio[g]),
        .clk_out   (raw_clk[g])
      );
    end
  endgenerate

  fsdiv_lag #(.DEPTH(PCI_LAG)) u_lag_pci (
    .clk (src_clk), .rst_n (rst_n), .d (raw_clk[I_PCI]), .q (pci_clk)
  );
  fsdiv_lag #(.DEPTH(PCI_LAG)) u_lag_api (
    .clk (src_clk), .rst_n (rst_n), .d (raw_clk[I_API]), .q (apic_clk)
  );

  assign cpu_clk       = raw_clk[I_CPU];
  assign sdram_clk     = raw_clk[I_SD];
  assign hub_clk       = raw_clk[I_HUB];
  assign cpu_ratio_now = active_ratio[I_CPU];
  assign sd_ratio_now  = active_ratio[I_SD];
endmodule

module fs_clock_divider_chk
  import fsdiv_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              phase_zero,
  input ratio_t            cpu_ratio,
  input ratio_t            sd_ratio,
  input ratio_t [NOUT-1:0] active_ratio,
  input logic              cpu_clk,
  input logic              hub_clk,
  input logic              pci_clk,
  input logic              apic_clk
);
  AST_SD_RATIO_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_ratio) |-> phase_zero); // R8

  AST_CPU_RATIO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> $stable(cpu_ratio)); // R5

  AST_FAST_SD_NEEDS_FAST_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_ratio == ratio_t'(3)) |-> (cpu_ratio == ratio_t'(3))); // R4

  AST_APIC_MATCHES_PCI: assert property (@(posedge clk) disable iff (!rst_n)
    apic_clk == pci_clk); // R9

  AST_FRAME_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    phase_zero |-> (cpu_clk && hub_clk)); // R7

  generate
    for (genvar g = 0; g < NOUT; g++) begin : g_rng
      AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (active_ratio[g] >= ratio_t'(2)) && (active_ratio[g] <= ratio_t'(12))); // R1
    end
  endgenerate
endmodule

bind fs_clock_divider fs_clock_divider_chk u_chk (
  .clk          (src_clk),
  .rst_n        (rst_n),
  .phase_zero   (phase_zero),
  .cpu_ratio    (cpu_ratio_now),
  .sd_ratio     (sd_ratio_now),
  .active_ratio (active_ratio),
  .cpu_clk      (cpu_clk),
  .hub_clk      (hub_clk),
  .pci_clk      (pci_clk),
  .apic_clk     (apic_clk)
);

// File: tb/fs_clock_divider_tb.sv
module fs_clock_divider_tb;
  localparam int LAG = 2;

  logic rclk = 1'b0, tclk = 1'b0;
  logic rst_n = 1'b0, tm = 1'b0, boost = 1'b0;
  logic [1:0] fs = 2'b00;
  logic cpu, sd, hub, pci, api;
  logic bsrc;

  always #2 rclk = ~rclk;
  always #3 tclk = ~tclk;
  assign bsrc = tm ? tclk : rclk;

  fs_clock_divider #(.FRAME(12), .PCI_LAG(LAG)) u_dut (
    .ref_clk(rclk), .test_clk(tclk), .rst_n(rst_n), .test_mode(tm),
    .fs_sel(fs), .sdram_boost(boost),
    .cpu_clk(cpu), .sdram_clk(sd), .hub_clk(hub), .pci_clk(pci), .apic_clk(api)
  );

  typedef struct packed {
    logic [2:0] idx;
    logic [4:0] rmin;
    logic [4:0] rmax;
    logic       fresh;
  } item_t;

  item_t itemq[$];
  string tagq[$];
  int    nchk = 0, nerr = 0;
  bit    busy = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic half();
    @(bsrc); #1;
  endtask

  function automatic logic pick(input int i);
    case (i)
      0: return cpu;
      1: return sd;
      2: return hub;
      3: return pci;
      default: return api;
    endcase
  endfunction

  task automatic sync_rise(input int i);
    while (pick(i)) half();
    while (!pick(i)) half();
  endtask

  // Driver side: expected run length in source half-periods (ratio R -> R high, R low).
  task automatic push(input int i, input int rmin, input int rmax, input bit fresh, input string tag);
    item_t it;
    it.idx = 3'(i); it.rmin = 5'(rmin); it.rmax = 5'(rmax); it.fresh = fresh;
    itemq.push_back(it);
    tagq.push_back(tag);
  endtask

  task automatic drain();
    half();
    while (itemq.size() != 0 || busy) half();
  endtask

  // Monitor: pops expectations and measures the matching output.
  initial begin
    forever begin
      item_t it;
      string tg;
      int hi, lo;
      wait (itemq.size() > 0);
      busy = 1;
      it = itemq.pop_front();
      tg = tagq.pop_front();
      if (it.fresh) sync_rise(int'(it.idx));
      hi = 0;
      while (pick(int'(it.idx))) begin hi++; half(); end
      lo = 0;
      while (!pick(int'(it.idx))) begin lo++; half(); end
      chk(hi >= int'(it.rmin) && hi <= int'(it.rmax), {tg, " high run"}, hi, int'(it.rmax));
      chk(lo >= int'(it.rmin) && lo <= int'(it.rmax), {tg, " low run"}, lo, int'(it.rmax));
      busy = 0;
    end
  end

  function automatic int exp_cpu(input logic [1:0] f);
    if (f == 2'b00) return 6;
    if (f == 2'b01) return 4;
    return 3;
  endfunction

  function automatic int exp_sd(input logic [1:0] f, input logic b);
    if (f[1] && (!f[0] || b)) return 3;
    return 4;
  endfunction

  task automatic do_reset(input logic [1:0] f, input logic t, input logic b);
    rst_n = 1'b0;
    #7;
    tm = t; fs = f; boost = b;
    #120;
    chk({cpu, sd, hub, pci, api} == 5'b0, "R10 outputs low in reset", int'({cpu, sd, hub, pci, api}), 0);
    @(negedge bsrc); #1;
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int n, mism;
    // Straps 00
    do_reset(2'b00, 1'b0, 1'b0);
    push(0, 2*exp_cpu(2'b00)/2, exp_cpu(2'b00), 1, "R1 cpu fs00");
    push(1, exp_sd(2'b00, 0), exp_sd(2'b00, 0), 1, "R2 sdram fs00");
    push(2, 6, 6, 1, "R3 hub");
    push(3, 12, 12, 1, "R3 pci");
    push(4, 12, 12, 1, "R9 apic");
    drain();
    // Straps moved after reset plus boost: must be ignored
    fs = 2'b11; boost = 1'b1;
    repeat (40) half();
    push(0, 6, 6, 1, "R5 cpu after strap change");
    push(1, 4, 4, 1, "R4 sdram boost ignored at fs00");
    drain();
    // PCI lag behind hub
    while (pci) half();
    while (!pci) half();
    n = 0;
    while (hub) begin n++; half(); end
    while (!hub) begin n++; half(); end
    chk(n == 2 * (6 - LAG), "R9 pci to next hub spacing", n, 2 * (6 - LAG));
    mism = 0;
    for (int k = 0; k < 48; k++) begin
      if (pci !== api) mism++;
      half();
    end
    chk(mism == 0, "R9 apic equals pci", mism, 0);

    // Straps 01
    do_reset(2'b01, 1'b0, 1'b0);
    push(0, exp_cpu(2'b01), exp_cpu(2'b01), 1, "R1 cpu fs01");
    push(1, 4, 4, 1, "R2 sdram fs01");
    drain();
    boost = 1'b1;
    repeat (40) half();
    push(1, 4, 4, 1, "R4 sdram boost ignored at fs01");
    drain();

    // Straps 10
    do_reset(2'b10, 1'b0, 1'b0);
    push(0, 3, 3, 1, "R7 cpu ratio3 duty");
    push(1, exp_sd(2'b10, 0), exp_sd(2'b10, 0), 1, "R2 sdram fs10");
    drain();

    // Straps 11 with run-time boost
    do_reset(2'b11, 1'b0, 1'b0);
    push(0, 3, 3, 1, "R1 cpu fs11");
    push(1, 4, 4, 1, "R2 sdram fs11 no boost");
    drain();
    boost = 1'b1;
    push(1, 3, 4, 1, "R8 sdram during raise");
    for (int k = 0; k < 8; k++) push(1, 3, 4, 0, "R8 sdram during raise");
    drain();
    push(1, 3, 3, 1, "R2 sdram boosted");
    push(2, 6, 6, 1, "R3 hub after boost");
    push(3, 12, 12, 1, "R3 pci after boost");
    drain();
    boost = 1'b0;
    push(0, 3, 3, 1, "R8 cpu during lower");
    for (int k = 0; k < 10; k++) push(0, 3, 3, 0, "R8 cpu during lower");
    drain();
    push(1, 4, 4, 1, "R2 sdram back to 4");
    drain();

    // Test mode
    do_reset(2'b00, 1'b1, 1'b0);
    push(0, 2, 2, 1, "R6 cpu test");
    push(1, 2, 2, 1, "R6 sdram test");
    push(2, 3, 3, 1, "R6 hub test");
    push(3, 6, 6, 1, "R6 pci test");
    push(4, 6, 6, 1, "R6 apic test");
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule